// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between the interrupt sources and the processor core. In every cycle where the core reports that it can take an exception, the block looks at one non-maskable request and one maskable request. The maskable request carries a 4-bit priority level and a vector number. The block decides whether either request is taken. When one is taken, it produces a one-cycle accept pulse and keeps the vector number of the winning source. It also raises the stored interrupt mask level and tells the register-bank controller whether the exception may save its context into a register bank.

The mask level is held inside the block. The core can rewrite it through a write strobe, for example when software restores its status word. An accepted interrupt always overwrites the mask. A non-maskable request is internally one level above anything a 4-bit field can express. Because of that it bypasses the mask compare, but it can only store the highest 4-bit value, 15. A maskable request marked as coming from a system source, such as a debug break or an address error, is taken like any other maskable request. It is, however, reported as not eligible for register-bank saving.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, acceptPulse is 0, maskLevel is 15 (all ones), vectorOut is 0 and bankOk is 0.
- R2: With coreReady high, a non-maskable request is accepted at any mask level, including 15. At the next clock edge acceptPulse goes to 1, vectorOut becomes NMI_VEC (default 11), maskLevel becomes 15 and bankOk becomes 0.
- R3: With coreReady high, a maskable request is accepted only when irqLevel is strictly greater than maskLevel. A level equal to the mask or below it is not accepted.
- R4: When a maskable request is accepted, maskLevel takes irqLevel and vectorOut takes irqVector at the same clock edge that raises acceptPulse.
- R5: When both requests are pending in one eligible cycle, the non-maskable request is taken and the maskable one is dropped.
- R6: While coreReady is low, nothing is accepted, and vectorOut and bankOk keep their values. maskLevel keeps its value unless maskWrEn is high.
- R7: A mask level of 15 blocks every maskable request.
- R8: bankOk is 1 after an accepted maskable request with irqSysSrc = 0. It is 0 after an accepted non-maskable request, and 0 after an accepted maskable request with irqSysSrc = 1.
- R9: acceptPulse is never high in two consecutive cycles. The cycle right after an accept is not evaluated, even with requests held.
- R10: With maskWrEn high and no acceptance at that edge, maskLevel takes maskWrData. When an acceptance happens at the same edge, the accepted level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReady | input | 1 | Core can take an exception this cycle |
| nmiReq | input | 1 | Non-maskable interrupt request |
| irqReq | input | 1 | Maskable interrupt request |
| irqLevel | input | LVL_W | Priority level of the maskable request |
| irqVector | input | VEC_W | Vector number of the maskable request |
| irqSysSrc | input | 1 | Maskable request comes from a debug-break or address-error source |
| maskWrEn | input | 1 | Core rewrites the mask level |
| maskWrData | input | LVL_W | New mask level from the core |
| acceptPulse | output | 1 | One-cycle pulse: a request was taken |
| vectorOut | output | VEC_W | Vector number of the last accepted source |
| maskLevel | output | LVL_W | Current interrupt mask level |
| bankOk | output | 1 | Last accepted exception may use register banks |

## Verification
The bench targets the compare boundary: a level equal to the mask, one step above it, level 15 against mask 14, and level 1 against mask 0. A design that used greater-or-equal would take the equal case, and one with an off-by-one in the compare would miss the adjacent case. Other vectors set the mask to 15 and present a maskable request, then a non-maskable one. A design that let level 15 through, or that masked the non-maskable path, would show up there. Further checks cover a maskable and a non-maskable request pending together, a held request that would give back-to-back pulses if the post-accept cycle were still evaluated, a mask write at the same edge as an acceptance, and the bank flag for system sources, which a design that ignored the source class would leave set.

// File: rtl/iau_pkg.sv
package iau_pkg;
  // Strobes from the decision logic to the datapath registers.
  typedef struct packed {
    logic takeNmi;  // non-maskable request taken this edge
    logic takeIrq;  // maskable request taken this edge
  } iauStrobes_t;
endpackage

// File: rtl/iau_ctrl.sv
module iau_ctrl
  import iau_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreReady,
  input  logic             nmiReq,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [LVL_W-1:0] maskLevel,
  output iauStrobes_t      strobes,
  output logic             acceptPulse
);
  logic evalCycle;
  logic irqAbove;

  // The cycle right after an accept is skipped, so the pulse stays one cycle wide.
  assign evalCycle = coreReady && !acceptPulse;
  assign irqAbove  = irqLevel > maskLevel;

  always_comb begin
    strobes         = '0;
    strobes.takeNmi = evalCycle && nmiReq;
    strobes.takeIrq = evalCycle && !nmiReq && irqReq && irqAbove;
  end

  always_ff @(posedge clk) begin
    if (!rstN) acceptPulse <= 1'b0;
    else       acceptPulse <= strobes.takeNmi || strobes.takeIrq;
  end

  // R9: no back-to-back pulses
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> !acceptPulse);

  // R6: no acceptance while the core is busy
  p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !coreReady |=> !acceptPulse);

  // R2: a non-maskable request in an eligible cycle is always taken
  p_nmi_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    (coreReady && nmiReq && !acceptPulse) |=> acceptPulse);

  // R5: the two take strobes never fire together
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes) <= 1);
endmodule

// File: rtl/iau_datapath.sv
module iau_datapath
  import iau_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  iauStrobes_t      strobes,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             irqSysSrc,
  input  logic             maskWrEn,
  input  logic [LVL_W-1:0] maskWrData,
  output logic [LVL_W-1:0] maskLevel,
  output logic [VEC_W-1:0] vectorOut,
  output logic             bankOk
);
  localparam logic [LVL_W-1:0] TOP_MASK = {LVL_W{1'b1}};
  localparam logic [VEC_W-1:0] NMI_VEC_V = VEC_W'(NMI_VEC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskLevel <= TOP_MASK;
      vectorOut <= '0;
      bankOk    <= 1'b0;
    end else if (strobes.takeNmi) begin
      maskLevel <= TOP_MASK;    // level above the field saturates to all ones
      vectorOut <= NMI_VEC_V;
      bankOk    <= 1'b0;
    end else if (strobes.takeIrq) begin
      maskLevel <= irqLevel;
      vectorOut <= irqVector;
      bankOk    <= !irqSysSrc;
    end else if (maskWrEn) begin
      maskLevel <= maskWrData;
    end
  end

  // R2: non-maskable acceptance leaves the mask at all ones
  p_nmi_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeNmi |=> (maskLevel == TOP_MASK) && (vectorOut == NMI_VEC_V));

  // R4: maskable acceptance copies the request level
  p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeIrq |=> maskLevel == $past(irqLevel));

  // R3: an accepted maskable request always raises the mask
  p_mask_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeIrq |=> maskLevel > $past(maskLevel));

  // R6: without acceptance or write the mask is kept
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.takeNmi && !strobes.takeIrq && !maskWrEn) |=> $stable(maskLevel));

  // R8: non-maskable exceptions never use register banks
  p_bank_nmi_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeNmi |=> !bankOk);
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import iau_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreReady,
  input  logic             nmiReq,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             irqSysSrc,
  input  logic             maskWrEn,
  input  logic [LVL_W-1:0] maskWrData,
  output logic             acceptPulse,
  output logic [VEC_W-1:0] vectorOut,
  output logic [LVL_W-1:0] maskLevel,
  output logic             bankOk
);
  iauStrobes_t strobes;

  iau_ctrl #(.LVL_W(LVL_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .coreReady  (coreReady),
    .nmiReq     (nmiReq),
    .irqReq     (irqReq),
    .irqLevel   (irqLevel),
    .maskLevel  (maskLevel),
    .strobes    (strobes),
    .acceptPulse(acceptPulse)
  );

  iau_datapath #(.LVL_W(LVL_W), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .irqLevel  (irqLevel),
    .irqVector (irqVector),
    .irqSysSrc (irqSysSrc),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .maskLevel (maskLevel),
    .vectorOut (vectorOut),
    .bankOk    (bankOk)
  );

  // R7: with the mask at all ones only the non-maskable path can fire
  p_top_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskLevel == {LVL_W{1'b1}} && !nmiReq) |=> !acceptPulse);
endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
  localparam int NMI_V = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       coreReady = 1'b0, nmiReq = 1'b0, irqReq = 1'b0, irqSysSrc = 1'b0, maskWrEn = 1'b0;
  logic [3:0] irqLevel = '0, maskWrData = '0;
  logic [7:0] irqVector = '0;
  logic       acceptPulse, bankOk;
  logic [7:0] vectorOut;
  logic [3:0] maskLevel;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_accept_unit #(.LVL_W(4), .VEC_W(8), .NMI_VEC(NMI_V)) i_irq_accept_unit (
    .clk(clk), .rstN(rstN), .coreReady(coreReady), .nmiReq(nmiReq), .irqReq(irqReq),
    .irqLevel(irqLevel), .irqVector(irqVector), .irqSysSrc(irqSysSrc),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .acceptPulse(acceptPulse),
    .vectorOut(vectorOut), .maskLevel(maskLevel), .bankOk(bankOk)
  );

  typedef struct packed {
    logic [3:0] mask; logic nmi; logic irq; logic [3:0] lvl; logic [7:0] vec;
    logic sys; logic rdy; logic expAcc; logic [3:0] expMask; logic [7:0] expVec; logic expBank;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t ROWS [NROWS] = '{
    '{4'd3,  1'b0, 1'b1, 4'd5,  8'h40, 1'b0, 1'b1, 1'b1, 4'd5,  8'h40, 1'b1}, // R3 R4 R8 above mask
    '{4'd5,  1'b0, 1'b1, 4'd5,  8'h41, 1'b0, 1'b1, 1'b0, 4'd5,  8'h00, 1'b0}, // R3 equal level
    '{4'd5,  1'b0, 1'b1, 4'd4,  8'h42, 1'b0, 1'b1, 1'b0, 4'd5,  8'h00, 1'b0}, // R3 below mask
    '{4'd15, 1'b0, 1'b1, 4'd15, 8'h43, 1'b0, 1'b1, 1'b0, 4'd15, 8'h00, 1'b0}, // R7 top mask
    '{4'd15, 1'b1, 1'b0, 4'd0,  8'h00, 1'b0, 1'b1, 1'b1, 4'd15, 8'd11, 1'b0}, // R2 nmi through top mask
    '{4'd0,  1'b1, 1'b1, 4'd9,  8'h50, 1'b0, 1'b1, 1'b1, 4'd15, 8'd11, 1'b0}, // R5 nmi wins
    '{4'd2,  1'b0, 1'b1, 4'd7,  8'h60, 1'b1, 1'b1, 1'b1, 4'd7,  8'h60, 1'b0}, // R8 system source
    '{4'd2,  1'b1, 1'b1, 4'd7,  8'h61, 1'b0, 1'b0, 1'b0, 4'd2,  8'h00, 1'b0}, // R6 core busy
    '{4'd0,  1'b0, 1'b1, 4'd1,  8'h22, 1'b0, 1'b1, 1'b1, 4'd1,  8'h22, 1'b1}, // R3 low boundary
    '{4'd14, 1'b0, 1'b1, 4'd15, 8'h7f, 1'b0, 1'b1, 1'b1, 4'd15, 8'h7f, 1'b1}, // R3 high boundary
    '{4'd0,  1'b0, 1'b0, 4'd9,  8'h33, 1'b0, 1'b1, 1'b0, 4'd0,  8'h00, 1'b0}  // R3 no request
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    coreReady = 1'b0; nmiReq = 1'b0; irqReq = 1'b0; irqSysSrc = 1'b0;
    maskWrEn = 1'b0; irqLevel = '0; irqVector = '0; maskWrData = '0;
  endtask

  initial begin
    int lastVec;
    int lastBank;
    repeat (3) @(negedge clk);
    check("R1 accept", acceptPulse, 0);
    check("R1 mask", maskLevel, 15);
    check("R1 vector", vectorOut, 0);
    check("R1 bank", bankOk, 0);
    rstN = 1'b1;
    lastVec = 0; lastBank = 0;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      idleInputs();
      maskWrEn = 1'b1; maskWrData = ROWS[i].mask;
      @(negedge clk);
      check("R10 mask write", maskLevel, ROWS[i].mask);
      idleInputs();
      coreReady = ROWS[i].rdy; nmiReq = ROWS[i].nmi; irqReq = ROWS[i].irq;
      irqLevel = ROWS[i].lvl; irqVector = ROWS[i].vec; irqSysSrc = ROWS[i].sys;
      @(negedge clk);
      check($sformatf("R3 accept row %0d", i), acceptPulse, ROWS[i].expAcc);
      check($sformatf("R4 mask row %0d", i), maskLevel, ROWS[i].expMask);
      if (ROWS[i].expAcc) begin
        lastVec = ROWS[i].expVec; lastBank = ROWS[i].expBank;
      end
      check($sformatf("R4 vector row %0d", i), vectorOut, lastVec);
      check($sformatf("R8 bank row %0d", i), bankOk, lastBank);
      idleInputs();
    end

    // R9: held non-maskable request gives pulses on alternate cycles
    @(negedge clk);
    coreReady = 1'b1; nmiReq = 1'b1;
    @(negedge clk); check("R9 first pulse", acceptPulse, 1);
    @(negedge clk); check("R9 gap cycle", acceptPulse, 0);
    @(negedge clk); check("R9 next pulse", acceptPulse, 1);
    idleInputs();

    // R10: acceptance beats a same-edge mask write
    @(negedge clk);
    maskWrEn = 1'b1; maskWrData = 4'd3;
    @(negedge clk);
    maskWrData = 4'd1; coreReady = 1'b1; irqReq = 1'b1; irqLevel = 4'd9; irqVector = 8'h19;
    @(negedge clk);
    check("R10 accept wins", maskLevel, 9);
    check("R10 accept pulse", acceptPulse, 1);
    idleInputs();

    // R1: reset in mid-run restores initial state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset mask", maskLevel, 15);
    check("R1 re-reset vector", vectorOut, 0);
    check("R1 re-reset accept", acceptPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule